// File: doc/BRIEF.md
# Memory-to-I/O Window Address Bridge

The bridge sits between a CPU's memory-space request channel and a narrow I/O-port bus. A CPU access that lands inside an 8 MB window starting at 0x80000000 becomes one I/O-port bus cycle. The bridge translates the address into a 16-bit port number and converts the data between big-endian CPU byte order and the little-endian I/O bus. Two port mappings are available, selected by a plain mode pin. In the flat mapping the port number is taken straight from the low address bits. In the sparse mapping only the low five address bits and the 4 KB page number are packed together, so each port can sit on its own page.

A second, four-byte region serves interrupt acknowledge. A read of its first byte address pulses a strobe to an external interrupt controller, samples the vector that the controller presents, and returns it in CPU byte order. Any other access to that region completes without side effects. Addresses outside both regions are accepted and dropped.

Requests and responses use valid/ready. A request is taken only while `req_ready` is high, and `req_ready` stays low from acceptance until the response has been taken. A response holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is seen high at a clock edge. The I/O side holds its cycle until `io_ready`.

Top module: `ioewin_bridge`

## Requirements
- R1: A request whose address lies in 0x80000000..0x807FFFFF is claimed (`req_hit` high while it is offered). It produces exactly one I/O cycle, and `io_valid`, `io_addr`, `io_size`, `io_write` and `io_wdata` stay steady until `io_ready` is sampled high. Only after that does a response follow.
- R2: With `map_sparse` low, `io_addr` equals address bits 15:0.
- R3: With `map_sparse` high, `io_addr` equals address bits 22:12 placed at port bits 15:5, ORed with address bits 4:0 at port bits 4:0. Address bits 11:5 are ignored.
- R4: Size codes are 00 for byte, 01 for halfword and 10 or 11 for word. Write data is byte-swapped onto `io_wdata`. A byte passes `req_wdata[7:0]` unchanged. A halfword swaps the two bytes of `req_wdata[15:0]`. A word reverses all four bytes. Unused upper lanes are zero.
- R5: Read data from `io_rdata` reaches `rsp_rdata` with the same per-size lane swap as in R4. An I/O write responds with zero data.
- R6: A read at exactly 0xBFFFFFF0 drives `intack_strobe` high for exactly one cycle and starts no I/O cycle. `rsp_rdata` is then the 8-bit `intack_vec` sampled during the strobe, zero-extended and swapped per R4: byte 0x000000VV, halfword 0x0000VV00, word 0xVV000000.
- R7: Reads at 0xBFFFFFF1..0xBFFFFFF3 are claimed and return zero, with no strobe and no I/O cycle.
- R8: Writes anywhere in 0xBFFFFFF0..0xBFFFFFF3 are claimed and respond with zero data, with no strobe and no I/O cycle. A later vector read is unaffected.
- R9: Requests outside both regions see `req_hit` low, are accepted, and produce neither a response, an I/O cycle nor a strobe.
- R10: While a response is pending and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay steady. `req_ready` is low from acceptance until the response handshake.
- R11: The mapping mode is sampled when a request is accepted. Changing `map_sparse` during the I/O cycle does not alter `io_addr`.
- R12: After reset `req_ready` is high and `io_valid`, `rsp_valid` and `intack_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request offered |
| req_ready | output | 1 | Bridge can take a request |
| req_addr | input | 32 | CPU byte address |
| req_size | input | 2 | Access size code (00 byte, 01 half, 1x word) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | CPU write data, big-endian lanes |
| map_sparse | input | 1 | 0 = flat port map, 1 = sparse page map |
| req_hit | output | 1 | Offered request falls in a claimed region |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_rdata | output | 32 | Response data, big-endian lanes |
| io_valid | output | 1 | I/O cycle in progress |
| io_ready | input | 1 | I/O device completes the cycle |
| io_addr | output | 16 | Port number |
| io_size | output | 2 | Access size code |
| io_write | output | 1 | I/O write |
| io_wdata | output | 32 | I/O write data, little-endian lanes |
| io_rdata | input | 32 | I/O read data, little-endian lanes |
| intack_strobe | output | 1 | One-cycle acknowledge pulse to the interrupt controller |
| intack_vec | input | 8 | Vector from the interrupt controller |

## Verification
The hardest case to reach from the ports is a mode change that lands while an I/O cycle is still open. The stimulus offers a sparse-mapped request, flips `map_sparse` on the very cycle after acceptance, and has the device model stall several cycles before it checks `io_addr`. A second hard case is response back-pressure together with the busy window. For that, `rsp_ready` is throttled to one cycle in three, and every pending cycle is checked for a steady response and a low `req_ready`. The writes to the acknowledge region are always followed by a vector read, so the block's normal response shows that nothing changed.

// File: rtl/ioewin_pkg.sv
package ioewin_pkg;

  localparam int DATA_W = 32;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_VEC  = 2'd2,
    ST_RESP = 2'd3
  } ioewin_state_e;

endpackage

// File: rtl/ioewin_lanes.sv
// Size-dependent byte-lane reversal between big- and little-endian order.
module ioewin_lanes #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB  = DATA_W / 8;
  localparam int NSZ = $clog2(NB) + 1;

  logic [NSZ-1:0][DATA_W-1:0] by_size;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    for (genvar i = 0; i < NB; i++) begin : g_lane
      if (i < (1 << s)) begin : g_used
        assign by_size[s][i*8 +: 8] = din[((1 << s) - 1 - i)*8 +: 8];
      end else begin : g_zero
        assign by_size[s][i*8 +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    if (int'(size) >= NSZ) dout = by_size[NSZ-1];
    else                   dout = by_size[size];
  end
endmodule

// File: rtl/ioewin_decode.sv
// Region decode and CPU-address to port-number translation.
module ioewin_decode #(
  parameter int                ADDR_W     = 32,
  parameter int                PORT_W     = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
  parameter int                WIN_BYTES  = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] ACK_ADDR   = 32'hBFFF_FFF0,
  parameter int                ACK_BYTES  = 4,
  parameter int                SPARSE_LO  = 5,
  parameter int                PAGE_LSB   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sparse,
  output logic              io_hit,
  output logic              ack_hit,
  output logic              ack_exact,
  output logic [PORT_W-1:0] port
);
  localparam int WIN_AW   = $clog2(WIN_BYTES);
  localparam int ACK_AW   = $clog2(ACK_BYTES);
  localparam int SPARSE_W = (WIN_AW - PAGE_LSB) + SPARSE_LO;

  logic [SPARSE_W-1:0] sparse_raw;
  logic [PORT_W-1:0]   flat_port;
  logic [PORT_W-1:0]   sparse_port;

  assign io_hit    = (addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign ack_hit   = (addr[ADDR_W-1:ACK_AW] == ACK_ADDR[ADDR_W-1:ACK_AW]);
  assign ack_exact = (addr == ACK_ADDR);

  // Page number lands just above the kept low bits; bits between are dropped.
  assign sparse_raw  = {addr[WIN_AW-1:PAGE_LSB], addr[SPARSE_LO-1:0]};
  assign sparse_port = PORT_W'(sparse_raw);
  assign flat_port   = addr[PORT_W-1:0];
  assign port        = sparse ? sparse_port : flat_port;
endmodule

// File: rtl/ioewin_ctrl.sv
// Transaction sequencer: request acceptance, I/O cycle, vector fetch, response.
module ioewin_ctrl
  import ioewin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 16,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] wr_lanes,
  input  logic              io_hit,
  input  logic              ack_hit,
  input  logic              ack_exact,
  input  logic [PORT_W-1:0] port,
  output logic              req_hit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              io_valid,
  input  logic              io_ready,
  output logic [PORT_W-1:0] io_addr,
  output logic [SIZE_W-1:0] io_size,
  output logic              io_write,
  output logic [DATA_W-1:0] io_wdata,
  output logic              intack_strobe,
  output logic              rd_from_vec,
  output logic [SIZE_W-1:0] held_size,
  input  logic [DATA_W-1:0] rd_lanes
);
  ioewin_state_e     state;
  logic [PORT_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  assign req_ready     = (state == ST_IDLE);
  assign req_hit       = req_valid && (io_hit || ack_hit);
  assign io_valid      = (state == ST_BUS);
  assign intack_strobe = (state == ST_VEC);
  assign rd_from_vec   = (state == ST_VEC);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign io_addr       = addr_q;
  assign io_size       = size_q;
  assign io_write      = write_q;
  assign io_wdata      = wdata_q;
  assign held_size     = size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (io_hit) begin
              addr_q  <= port;
              size_q  <= req_size;
              write_q <= req_write;
              wdata_q <= req_write ? wr_lanes : '0;
              state   <= ST_BUS;
            end else if (ack_hit) begin
              size_q  <= req_size;
              write_q <= 1'b0;
              rdata_q <= '0;
              state   <= (!req_write && ack_exact) ? ST_VEC : ST_RESP;
            end
          end
        end
        ST_BUS: begin
          if (io_ready) begin
            rdata_q <= write_q ? '0 : rd_lanes;
            state   <= ST_RESP;
          end
        end
        ST_VEC: begin
          rdata_q <= rd_lanes;
          state   <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: pending response is held
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R10: no new request while a response is outstanding
  a_r10_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R1: the I/O cycle stays put until the device answers
  a_r1_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_wdata) && $stable(io_size));

  // R6: the acknowledge strobe lasts a single cycle
  a_r6_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
    intack_strobe |=> !intack_strobe);

  // R8: writes into the acknowledge region stay quiet
  a_r8_ack_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ack_hit && req_write |=> !intack_strobe && !io_valid && rsp_valid);

  // R9: an unclaimed request leaves the bridge idle
  a_r9_unclaimed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_hit |=> req_ready);
endmodule

// File: rtl/ioewin_bridge.sv
// Top: memory-space window to I/O-port bus with interrupt-acknowledge location.
module ioewin_bridge
  import ioewin_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                PORT_W    = 16,
  parameter int                VEC_W     = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  parameter int                WIN_BYTES = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] ACK_ADDR  = 32'hBFFF_FFF0,
  parameter int                ACK_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              map_sparse,
  output logic              req_hit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              io_valid,
  input  logic              io_ready,
  output logic [PORT_W-1:0] io_addr,
  output logic [SIZE_W-1:0] io_size,
  output logic              io_write,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              intack_strobe,
  input  logic [VEC_W-1:0]  intack_vec
);
  logic              io_hit, ack_hit, ack_exact;
  logic [PORT_W-1:0] port;
  logic [DATA_W-1:0] wr_lanes, rd_lanes, rd_src;
  logic              rd_from_vec;
  logic [SIZE_W-1:0] held_size;

  ioewin_decode #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .ACK_ADDR(ACK_ADDR), .ACK_BYTES(ACK_BYTES), .SPARSE_LO(5), .PAGE_LSB(12)
  ) u_decode (
    .addr(req_addr), .sparse(map_sparse), .io_hit(io_hit),
    .ack_hit(ack_hit), .ack_exact(ack_exact), .port(port)
  );

  ioewin_lanes #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_wr_lanes (
    .size(req_size), .din(req_wdata), .dout(wr_lanes)
  );

  assign rd_src = rd_from_vec ? DATA_W'(intack_vec) : io_rdata;

  ioewin_lanes #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_rd_lanes (
    .size(held_size), .din(rd_src), .dout(rd_lanes)
  );

  ioewin_ctrl #(.DATA_W(DATA_W), .PORT_W(PORT_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
    .req_write(req_write), .wr_lanes(wr_lanes),
    .io_hit(io_hit), .ack_hit(ack_hit), .ack_exact(ack_exact), .port(port),
    .req_hit(req_hit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
    .io_size(io_size), .io_write(io_write), .io_wdata(io_wdata),
    .intack_strobe(intack_strobe), .rd_from_vec(rd_from_vec),
    .held_size(held_size), .rd_lanes(rd_lanes)
  );
endmodule

// File: tb/ioewin_bridge_test.sv
module ioewin_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [15:0] a;
    logic [1:0]  sz;
    logic        w;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [3:0]  dly;
  } io_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        map_sparse = 1'b0;
  logic        req_hit;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        io_valid;
  logic        io_ready = 1'b0;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic        io_write;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata = '0;
  logic        intack_strobe;
  logic [7:0]  intack_vec = 8'h5A;

  int checks = 0;
  int errors = 0;
  int strobe_cnt = 0;
  int cyc = 0;
  logic bp_on = 1'b0;
  logic done = 1'b0;

  io_item_t    exp_io[$];
  string       io_tag[$];
  logic [31:0] exp_rsp[$];
  string       rsp_tag[$];

  ioewin_bridge uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  // Driver: push expectations, then offer the request until accepted.
  task automatic send(input logic [31:0] a, input logic [1:0] sz, input logic w,
                      input logic [31:0] wd, input logic exp_hit, input string tag);
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = w; req_wdata = wd; req_valid = 1'b1;
    #1;
    check(req_hit == exp_hit, {tag, " req_hit"}, 32'(req_hit), 32'(exp_hit));
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic io_op(input logic [31:0] a, input logic [1:0] sz, input logic w,
                       input logic [31:0] wd, input logic [15:0] ea, input logic [31:0] ewd,
                       input logic [31:0] dev_rd, input logic [31:0] ersp, input logic [3:0] dly,
                       input string tag);
    io_item_t it;
    it.a = ea; it.sz = sz; it.w = w; it.wd = ewd; it.rd = dev_rd; it.dly = dly;
    exp_io.push_back(it); io_tag.push_back(tag);
    exp_rsp.push_back(ersp); rsp_tag.push_back(tag);
    send(a, sz, w, wd, 1'b1, tag);
  endtask

  task automatic ack_op(input logic [31:0] a, input logic [1:0] sz, input logic w,
                        input logic [31:0] ersp, input string tag);
    exp_rsp.push_back(ersp); rsp_tag.push_back(tag);
    send(a, sz, w, 32'hFFFF_FFFF, 1'b1, tag);
  endtask

  task automatic drain();
    while (exp_rsp.size() != 0 || exp_io.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // I/O device model: checks the cycle after its latency, then answers.
  initial begin
    forever begin
      @(negedge clk);
      if (io_valid && !io_ready) begin
        if (exp_io.size() == 0) begin
          check(1'b0, "R9 unexpected io cycle", 32'(io_addr), 32'h0);
          io_ready = 1'b1;
        end else begin
          io_item_t it;
          string t;
          it = exp_io.pop_front(); t = io_tag.pop_front();
          repeat (it.dly) @(negedge clk);
          check(io_addr == it.a, {t, " io_addr"}, 32'(io_addr), 32'(it.a));
          check(io_size == it.sz && io_write == it.w, {t, " io_size/io_write"},
                {29'd0, io_size, io_write}, {29'd0, it.sz, it.w});
          if (it.w) check(io_wdata == it.wd, {t, " io_wdata"}, io_wdata, it.wd);
          io_rdata = it.rd;
          io_ready = 1'b1;
        end
        @(negedge clk);
        io_ready = 1'b0;
      end
    end
  end

  // Monitor: response scoreboard, back-pressure, strobe count, busy rule.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = bp_on ? (cyc % 3 == 0) : 1'b1;
      if (intack_strobe) strobe_cnt++;
      if (rsp_valid && req_ready) check(1'b0, "R10 req_ready high with response pending", 32'd1, 32'd0);
      if (rsp_valid && rsp_ready) begin
        if (exp_rsp.size() == 0) begin
          check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_rsp.pop_front(); t = rsp_tag.pop_front();
          check(rsp_rdata == e, {t, " rsp_rdata"}, rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'(cyc), 32'(WATCHDOG));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(req_ready === 1'b1, "R12 req_ready in reset", 32'(req_ready), 32'd1);
    check(io_valid === 1'b0 && rsp_valid === 1'b0 && intack_strobe === 1'b0,
          "R12 outputs idle in reset", {29'd0, io_valid, rsp_valid, intack_strobe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 flat map, R5 read swaps
    map_sparse = 1'b0;
    io_op(32'h8000_03F8, 2'b00, 1'b0, 0, 16'h03F8, 0, 32'h1122_3344, 32'h0000_0044, 4'd0, "R2 R5 byte read");
    io_op(32'h8000_0010, 2'b01, 1'b0, 0, 16'h0010, 0, 32'h1122_3344, 32'h0000_4433, 4'd1, "R5 half read");
    io_op(32'h8000_0020, 2'b10, 1'b0, 0, 16'h0020, 0, 32'h1122_3344, 32'h4433_2211, 4'd2, "R5 word read");
    io_op(32'h8000_0024, 2'b11, 1'b0, 0, 16'h0024, 0, 32'hCAFE_F00D, 32'h0DF0_FECA, 4'd0, "R4 R5 size 11 as word");
    io_op(32'h807F_FFFC, 2'b00, 1'b0, 0, 16'hFFFC, 0, 32'h0000_0077, 32'h0000_0077, 4'd0, "R1 R2 window top");
    // R4 write swaps
    io_op(32'h8000_1234, 2'b10, 1'b1, 32'hA1B2_C3D4, 16'h1234, 32'hD4C3_B2A1, 0, 0, 4'd1, "R4 word write");
    io_op(32'h8000_ABCD, 2'b01, 1'b1, 32'hA1B2_C3D4, 16'hABCD, 32'h0000_D4C3, 0, 0, 4'd0, "R4 half write");
    io_op(32'h8000_0061, 2'b00, 1'b1, 32'hA1B2_C3D4, 16'h0061, 32'h0000_00D4, 0, 0, 4'd3, "R4 byte write");
    drain();

    // R3 sparse map
    map_sparse = 1'b1;
    io_op(32'h8000_1003, 2'b00, 1'b0, 0, 16'h0023, 0, 32'h0000_0001, 32'h0000_0001, 4'd0, "R3 sparse page 1");
    io_op(32'h807F_F01F, 2'b00, 1'b0, 0, 16'hFFFF, 0, 32'h0000_0002, 32'h0000_0002, 4'd0, "R3 sparse top");
    io_op(32'h8000_0FE0, 2'b00, 1'b0, 0, 16'h0000, 0, 32'h0000_0003, 32'h0000_0003, 4'd0, "R3 sparse dropped bits");
    io_op(32'h8012_345A, 2'b01, 1'b1, 32'h0000_BEEF, 16'h247A, 32'h0000_EFBE, 0, 0, 4'd0, "R3 sparse mixed");
    drain();

    // R11 mode flip during an open I/O cycle
    io_op(32'h8000_2005, 2'b00, 1'b0, 0, 16'h0045, 0, 32'h0000_0099, 32'h0000_0099, 4'd4, "R11 mode sampled at accept");
    map_sparse = 1'b0;
    drain();

    // R6 vector reads
    s0 = strobe_cnt;
    intack_vec = 8'h5A;
    ack_op(32'hBFFF_FFF0, 2'b00, 1'b0, 32'h0000_005A, "R6 vector byte");
    ack_op(32'hBFFF_FFF0, 2'b01, 1'b0, 32'h0000_5A00, "R6 vector half");
    ack_op(32'hBFFF_FFF0, 2'b10, 1'b0, 32'h5A00_0000, "R6 vector word");
    drain();
    check(strobe_cnt - s0 == 3, "R6 strobe count", 32'(strobe_cnt - s0), 32'd3);

    // R7 other region reads, R8 writes
    s0 = strobe_cnt;
    ack_op(32'hBFFF_FFF2, 2'b10, 1'b0, 32'h0, "R7 region read off vector");
    ack_op(32'hBFFF_FFF1, 2'b00, 1'b0, 32'h0, "R7 region read byte");
    ack_op(32'hBFFF_FFF0, 2'b10, 1'b1, 32'h0, "R8 region write");
    ack_op(32'hBFFF_FFF3, 2'b00, 1'b1, 32'h0, "R8 region write high");
    drain();
    check(strobe_cnt == s0, "R7 R8 no strobe", 32'(strobe_cnt - s0), 32'd0);
    intack_vec = 8'hC3;
    ack_op(32'hBFFF_FFF0, 2'b00, 1'b0, 32'h0000_00C3, "R8 vector after writes");
    drain();

    // R9 unclaimed addresses
    s0 = strobe_cnt;
    send(32'h8080_0000, 2'b00, 1'b0, 0, 1'b0, "R9 above window");
    send(32'h7FFF_FFFF, 2'b00, 1'b1, 0, 1'b0, "R9 below window");
    send(32'hBFFF_FFEC, 2'b10, 1'b0, 0, 1'b0, "R9 below ack region");
    send(32'hBFFF_FFF4, 2'b00, 1'b0, 0, 1'b0, "R9 above ack region");
    repeat (5) @(negedge clk);
    check(strobe_cnt == s0 && !rsp_valid && !io_valid, "R9 nothing started",
          {30'd0, rsp_valid, io_valid}, 32'd0);

    // R10 back-pressure
    bp_on = 1'b1;
    io_op(32'h8000_0300, 2'b10, 1'b0, 0, 16'h0300, 0, 32'h0102_0304, 32'h0403_0201, 4'd0, "R10 held word read");
    ack_op(32'hBFFF_FFF0, 2'b01, 1'b0, 32'h0000_C300, "R10 held vector");
    io_op(32'h8000_0301, 2'b01, 1'b1, 32'h0000_1357, 16'h0301, 32'h0000_5713, 0, 0, 4'd2, "R10 held write");
    drain();
    bp_on = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule